// File: doc/BRIEF.md
# Shared-Period Input Debounce Filter

This block cleans up a bank of slow external inputs, such as buttons, straps or presence detects, before they reach edge or level detection logic. Every input has its own stability counter. The length of the quiet time that an input needs comes from one of three period registers, and all pins share those three registers. Each pin picks one of them, or it picks no filtering at all.

Software configures the block through a small register port. Two select planes each hold one bit per pin, and the two bits together form that pin's timer index. Three period registers hold lengths in clock cycles. A filtered pin copies its raw input only after the raw value has disagreed with the filtered value for the programmed number of consecutive clock edges. When software rewrites a setting that a pin depends on, that pin's count starts again from zero.

Top module: `dbf_top`

## Requirements
- R1: After reset, both select planes and all three period registers read 0, and every filtered output equals its raw input.
- R2: Register map. Offset 0x00 holds the index high-bit plane. Offset 0x04 holds the index low-bit plane. Offsets 0x50, 0x54 and 0x58 hold periods one, two and three. Each of these registers reads back what was last written to it. Other offsets read 0, and writes to them change nothing.
- R3: Pin n's timer index is {bit n of 0x00, bit n of 0x04}. Index 0 means bypass: the output equals the raw input in the same cycle.
- R4: Index 1 uses the period at 0x50, index 2 uses 0x54, and index 3 uses 0x58.
- R5: For a filtering pin with period P, the output takes the raw value right after the P-th consecutive rising edge at which the raw value differed from the output.
- R6: A raw pulse that lasts fewer than P edges never reaches the output. Once the raw value agrees with the output again, the count returns to zero.
- R7: A selected period of 0 acts as bypass, with no added delay.
- R8: A write that changes one of a pin's select bits, or changes the value of the period that pin selects, clears that pin's count. The edge of that write does not count. A write of an unchanged value has no effect.
- R9: Pins filter independently. Activity on one pin never alters another pin's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | 32 | Unfiltered pin levels |
| filt_out | output | 32 | Debounced pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
The assertions run on every cycle. They check that a committing edge loads the raw value and that a non-committing edge holds the filtered level. They also check that each counter stays below its period, that a configuration change clears the count, and that register writes stick and reset clears all settings. Only the bench's scenarios can show end-to-end effects. These include which period each index actually reaches, that a short glitch disappears at the pins, that unchanged rewrites leave the timing alone, and that pins stay independent. The bench shows them by comparing every cycle against a behavioural model while raw traffic and register writes are interleaved.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    localparam int unsigned OFF_SEL_HI   = 'h000;
    localparam int unsigned OFF_SEL_LO   = 'h004;
    localparam int unsigned OFF_PER_BASE = 'h050;
    localparam int unsigned PER_STRIDE   = 4;
    localparam int unsigned NUM_TIMERS   = 3;

    typedef enum logic [1:0] {
        TSEL_BYPASS = 2'd0,
        TSEL_ONE    = 2'd1,
        TSEL_TWO    = 2'd2,
        TSEL_THREE  = 2'd3
    } tsel_e;
endpackage

// File: rtl/dbf_regs.sv
module dbf_regs
    import dbf_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic [NUM_PINS-1:0]                 sel_hi_o,
    output logic [NUM_PINS-1:0]                 sel_lo_o,
    output logic [NUM_TIMERS-1:0][CNT_W-1:0]    per_o,
    output logic [NUM_PINS-1:0]                 chg_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0]              hi;
        logic [NUM_PINS-1:0]              lo;
        logic [NUM_TIMERS-1:0][CNT_W-1:0] per;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit_hi, hit_lo;
    logic [NUM_TIMERS-1:0] hit_per;

    always_comb begin
        hit_hi = (addr == ADDR_W'(OFF_SEL_HI));
        hit_lo = (addr == ADDR_W'(OFF_SEL_LO));
        for (int t = 0; t < NUM_TIMERS; t++) begin
            hit_per[t] = (addr == ADDR_W'(OFF_PER_BASE + PER_STRIDE * t));
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (hit_hi) cfg_d.hi = wdata[NUM_PINS-1:0];
            if (hit_lo) cfg_d.lo = wdata[NUM_PINS-1:0];
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (hit_per[t]) cfg_d.per[t] = wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_hi) rdata[NUM_PINS-1:0] = cfg_q.hi;
        if (hit_lo) rdata[NUM_PINS-1:0] = cfg_q.lo;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (hit_per[t]) rdata[CNT_W-1:0] = cfg_q.per[t];
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            chg_o[n] = 1'b0;
            if (we && hit_hi && (wdata[n] != cfg_q.hi[n])) chg_o[n] = 1'b1;
            if (we && hit_lo && (wdata[n] != cfg_q.lo[n])) chg_o[n] = 1'b1;
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (we && hit_per[t] && ({cfg_q.hi[n], cfg_q.lo[n]} == 2'(t + 1))
                    && (wdata[CNT_W-1:0] != cfg_q.per[t]))
                    chg_o[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sel_hi_o = cfg_q.hi;
    assign sel_lo_o = cfg_q.lo;
    assign per_o    = cfg_q.per;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sel_hi_o == '0 && sel_lo_o == '0 && per_o == '0));

    assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_hi) |=> (sel_hi_o == $past(wdata[NUM_PINS-1:0])));

    assert_per1_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_per[0]) |=> (per_o[0] == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/dbf_pin.sv
module dbf_pin
    import dbf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [1:0]       idx_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic             chg_i,
    output logic             out_o
);
    typedef struct packed {
        logic             filt;
        logic [CNT_W-1:0] cnt;
    } pin_t;

    pin_t st_d, st_q;
    logic byp;
    logic [CNT_W:0] cnt_inc;
    logic reach;

    always_comb begin
        byp     = (idx_i == 2'(TSEL_BYPASS)) || (per_i == '0);
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        reach   = (cnt_inc >= {1'b0, per_i});
        st_d    = st_q;
        if (byp) begin
            st_d.filt = raw_i;
            st_d.cnt  = '0;
        end else if (chg_i || (raw_i == st_q.filt)) begin
            st_d.cnt  = '0;
        end else if (reach) begin
            st_d.filt = raw_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = byp ? raw_i : st_q.filt;

    assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !chg_i && (raw_i != st_q.filt) && reach) |=> (st_q.filt == $past(raw_i)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !reach) |=> $stable(st_q.filt));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !byp |-> (st_q.cnt < per_i));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && chg_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/dbf_top.sv
module dbf_top
    import dbf_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] filt_out,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);
    logic [NUM_PINS-1:0]              sel_hi, sel_lo, chg;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] per_vec;

    dbf_regs #(
        .NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .sel_hi_o(sel_hi), .sel_lo_o(sel_lo), .per_o(per_vec),
        .chg_o(chg)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic [1:0]       idx;
        logic [CNT_W-1:0] per_sel;

        always_comb begin
            idx     = {sel_hi[n], sel_lo[n]};
            per_sel = '0;
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (idx == 2'(t + 1)) per_sel = per_vec[t];
            end
        end

        dbf_pin #(.CNT_W(CNT_W)) u_pin (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_in[n]), .idx_i(idx),
            .per_i(per_sel), .chg_i(chg[n]), .out_o(filt_out[n])
        );
    end
endmodule

// File: tb/sim_dbf_top.sv
`timescale 1ns/1ps
module sim_dbf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_in = '0;
    logic [31:0] filt_out;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dbf_top u0 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .filt_out(filt_out),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Behavioural reference model
    logic [31:0] m_hi, m_lo;
    longint      m_per [3];
    longint      m_cnt [32];
    bit          m_f   [32];

    function automatic longint m_period(int n);
        int ix;
        ix = {m_hi[n], m_lo[n]};
        if (ix == 0) return 0;
        return m_per[ix-1];
    endfunction

    function automatic logic [31:0] m_expect();
        logic [31:0] e;
        for (int n = 0; n < 32; n++)
            e[n] = (m_period(n) == 0) ? raw_in[n] : m_f[n];
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = '0; m_lo = '0;
            for (int t = 0; t < 3; t++) m_per[t] = 0;
            for (int n = 0; n < 32; n++) begin m_cnt[n] = 0; m_f[n] = 0; end
        end else begin
            for (int n = 0; n < 32; n++) begin
                longint p;
                bit c;
                int ix;
                ix = {m_hi[n], m_lo[n]};
                p = m_period(n);
                c = 0;
                if (reg_we && reg_addr == 12'h000 && reg_wdata[n] != m_hi[n]) c = 1;
                if (reg_we && reg_addr == 12'h004 && reg_wdata[n] != m_lo[n]) c = 1;
                for (int t = 0; t < 3; t++)
                    if (reg_we && reg_addr == 12'(80 + 4*t) && ix == t+1
                        && longint'(reg_wdata) != m_per[t]) c = 1;
                if (p == 0) begin
                    m_f[n] = raw_in[n]; m_cnt[n] = 0;
                end else if (c || raw_in[n] == m_f[n]) begin
                    m_cnt[n] = 0;
                end else begin
                    m_cnt[n] = m_cnt[n] + 1;
                    if (m_cnt[n] >= p) begin m_f[n] = raw_in[n]; m_cnt[n] = 0; end
                end
            end
            if (reg_we) begin
                if (reg_addr == 12'h000) m_hi = reg_wdata;
                if (reg_addr == 12'h004) m_lo = reg_wdata;
                for (int t = 0; t < 3; t++)
                    if (reg_addr == 12'(80 + 4*t)) m_per[t] = longint'(reg_wdata);
            end
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (filt_out !== m_expect()) begin
                bad++;
                $display("FAIL %s: filt_out=%h expected=%h", cur_req, filt_out, m_expect());
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        @(negedge clk);
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: rdata@%h=%h expected=%h", req, a, reg_rdata, exp);
        end
        tick();
    endtask

    task automatic run(input int n, input int dens, input string req);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            if ($urandom % dens == 0) raw_in = raw_in ^ ($urandom & $urandom & $urandom);
            tick();
        end
    endtask

    task automatic chk_bit(input int b, input logic exp, input string req);
        total++;
        if (filt_out[b] !== exp) begin
            bad++;
            $display("FAIL %s: filt_out[%0d]=%b expected=%b", req, b, filt_out[b], exp);
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset values
        rd(12'h000, 32'h0, "R1"); rd(12'h004, 32'h0, "R1");
        rd(12'h050, 32'h0, "R1"); rd(12'h054, 32'h0, "R1"); rd(12'h058, 32'h0, "R1");
        run(40, 1, "R1 R3 bypass after reset");
        // R2 register map
        wr(12'h050, 32'd5); wr(12'h054, 32'd1); wr(12'h058, 32'd12);
        wr(12'h010, 32'hDEADBEEF); wr(12'h05C, 32'h1234);
        rd(12'h050, 32'd5, "R2"); rd(12'h054, 32'd1, "R2"); rd(12'h058, 32'd12, "R2");
        rd(12'h010, 32'h0, "R2"); rd(12'h05C, 32'h0, "R2");
        rd(12'h000, 32'h0, "R2");
        // R3/R4 index map: 0-7 ->1, 8-15 ->2, 16-23 ->3, 24-31 bypass
        wr(12'h000, 32'h00FFFF00); wr(12'h004, 32'h00FF00FF);
        rd(12'h000, 32'h00FFFF00, "R2"); rd(12'h004, 32'h00FF00FF, "R2");
        raw_in = '0;
        run(30, 1000000, "R4 settle");
        // R5 explicit: pin 0 period 5
        raw_in[0] = 1'b1;
        repeat (4) tick();
        chk_bit(0, 1'b0, "R5 before 5th edge");
        tick();
        chk_bit(0, 1'b1, "R5 at 5th edge");
        // R6 explicit: 3-edge glitch on pin 1 is dropped
        raw_in[1] = 1'b1; repeat (3) tick(); raw_in[1] = 1'b0;
        repeat (10) tick();
        chk_bit(1, 1'b0, "R6 glitch dropped");
        // R9: pin 24 bypass follows while pin 16 (period 12) waits
        raw_in[24] = 1'b1; raw_in[16] = 1'b1; #1;
        chk_bit(24, 1'b1, "R3 R9 bypass immediate");
        chk_bit(16, 1'b0, "R9 filtered pin independent");
        run(20, 1000000, "R9");
        run(3000, 3, "R4 R5 R6 R9 random traffic");
        // R7: period 0 on timer three
        wr(12'h058, 32'd0);
        run(500, 2, "R7 zero period pass-through");
        wr(12'h058, 32'd12);
        // R8: restarts from config writes, plus unchanged rewrites
        for (int k = 0; k < 60; k++) begin
            run(7, 2, "R8 traffic");
            case (k % 5)
                0: wr(12'h050, (k % 2) ? 32'd5 : 32'd7);
                1: wr(12'h054, 32'd1);
                2: wr(12'h004, 32'h00FF00FF ^ (32'h1 << (k % 32)));
                3: wr(12'h004, 32'h00FF00FF);
                default: wr(12'h058, 32'd12);
            endcase
        end
        run(200, 4, "R8 R5 final");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule